// File: doc/BRIEF.md
# Multiword DMA Host Burst Sequencer

This block drives the host end of an ATA multiword DMA transfer over a 16-bit data bus. Once a transfer is armed with a word count and a direction, it waits for the device to raise its DMA request. When the request is present and the local stream can take part, it asserts the active-low DMA acknowledge. Both chip selects stay negated the whole time. It then issues a series of active-low read or write strobe pulses. Each pulse moves one 16-bit word between the bus and a valid/ready style stream: a source feeds write bursts and a sink receives read bursts.

Pulse width, minimum cycle time (strobe assertion to strobe assertion) and write-data setup are clock counts sampled when a transfer is armed. A transfer may be split into several bursts. The device can end a burst by dropping its request during a pulse, and the word of that pulse still completes. The host ends a burst at a pulse boundary when the source runs dry or the sink is full, and it resumes once the request is seen again with the stream ready. The transfer finishes when the programmed number of words has moved.

The controller has six states: `ST_IDLE`, `ST_WAIT_RQ`, `ST_SETUP`, `ST_STROBE`, `ST_RECOVER` and `ST_DONE`. The transitions are:
- `ST_IDLE` goes to `ST_WAIT_RQ` on a start, or to `ST_DONE` if the count is zero.
- `ST_WAIT_RQ` goes to `ST_SETUP` when the request is high and the stream is ready.
- `ST_SETUP` goes to `ST_STROBE` once both setup and cycle time are met.
- `ST_STROBE` goes to `ST_RECOVER` after the pulse width.
- `ST_RECOVER` goes to one of three states: `ST_DONE` when the count is exhausted, `ST_WAIT_RQ` on a device or host termination, or `ST_SETUP` otherwise.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `mdma_host_seq`

## Requirements
- R1: Out of reset, and whenever idle, `dmack_n`, `dior_n` and `diow_n` are 1, `dd_oe` and `xfer_busy` are 0. `cs0_n` and `cs1_n` are always 1.
- R2: `dmack_n` falls only in the cycle after one in which `dmarq` was 1 and the stream was ready. While `dmarq` stays 0, `dmack_n` stays 1.
- R3: Strobes appear only while `dmack_n` is 0. `cfg_write`=1 selects `diow_n` and `cfg_write`=0 selects `dior_n`. The two strobes are never low together.
- R4: Every strobe pulse lasts exactly max(`cfg_pulse`,1) clocks.
- R5: Within one burst, strobe assertions are exactly max(`cfg_cycle`, max(`cfg_pulse`,1)+1+max(`cfg_setup`,1)) clocks apart.
- R6: In a write burst, `dd_oe` is 1 and `dd_out` holds the word for at least max(`cfg_setup`,1) clocks before `diow_n` falls and for one clock after it rises. `src_ready` pops that word in the last strobe clock.
- R7: In a read burst, `snk_valid` is 1 for exactly the last strobe clock of each pulse, with `snk_data` equal to `dd_in` in that clock.
- R8: If `dmarq` is 0 in any clock of a pulse, that pulse's word still transfers. `dmack_n` returns to 1 one clock after the strobe ends, and no further strobe occurs before a new acknowledge.
- R9: If, one clock after a pulse, the source is empty (write) or the sink is not ready (read), `dmack_n` returns to 1. The burst resumes with a new acknowledge once `dmarq` and the stream are ready.
- R10: After `xfer_words` words, `xfer_done` pulses for one clock with `dmack_n` at 1. A count of zero gives `xfer_done` without any acknowledge. Completion takes precedence over a device termination on the final word, so no further acknowledge follows.
- R11: `xfer_start` and `xfer_words` are ignored while `xfer_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_write | input | 1 | 1 = write transfer, 0 = read transfer |
| cfg_pulse | input | 8 | Strobe width in clocks (0 acts as 1) |
| cfg_cycle | input | 8 | Minimum strobe-to-strobe period in clocks |
| cfg_setup | input | 8 | Clocks from data/acknowledge to strobe (0 acts as 1) |
| xfer_start | input | 1 | Arms a transfer when idle |
| xfer_words | input | 16 | Words in the transfer |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-clock completion pulse |
| dmarq | input | 1 | Device DMA request, active high |
| dmack_n | output | 1 | DMA acknowledge, active low |
| cs0_n | output | 1 | Chip select 0, held negated |
| cs1_n | output | 1 | Chip select 1, held negated |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_in | input | 16 | Bus data from the device |
| dd_out | output | 16 | Bus data to the device |
| dd_oe | output | 1 | Bus output enable |
| src_valid | input | 1 | Write source has a word |
| src_data | input | 16 | Write source head word |
| src_ready | output | 1 | Pops the write source |
| snk_ready | input | 1 | Read sink can take a word |
| snk_valid | output | 1 | Read word is presented |
| snk_data | output | 16 | Read word |

## Verification
Two cases can fall on the same clock.

The first is a device termination and word-count completion on one pulse. The device drops its request during the final pulse of a transfer. The only acceptable outcome is a single burst, one `xfer_done` and no re-acknowledge.

The second is a device termination and a host starvation on one pulse. The request drops on the pulse that also empties the sink. The bench counts acknowledges and words against the hand-derived totals, checks that the run completes, and checks that the data order is intact.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_RQ,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER,
        ST_DONE
    } mdma_state_e;

endpackage

// File: rtl/mdma_tick_cnt.sv
// Saturating up-counter with clear and preset-to-full.
module mdma_tick_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         preset,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (preset) begin
            cnt <= '1;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdma_word_ctr.sv
// Remaining-word counter of a transfer.
module mdma_word_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] left,
    output logic         is_zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left <= '0;
        end else if (load) begin
            left <= load_val;
        end else if (dec && (left != '0)) begin
            left <= left - 1'b1;
        end
    end

    assign is_zero = (left == '0);
endmodule

// File: rtl/mdma_host_seq.sv
module mdma_host_seq
    import mdma_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CFG_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_write,
    input  logic [CFG_W-1:0]  cfg_pulse,
    input  logic [CFG_W-1:0]  cfg_cycle,
    input  logic [CFG_W-1:0]  cfg_setup,
    input  logic              xfer_start,
    input  logic [CNT_W-1:0]  xfer_words,
    output logic              xfer_busy,
    output logic              xfer_done,
    input  logic              dmarq,
    output logic              dmack_n,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic              dior_n,
    output logic              diow_n,
    input  logic [DATA_W-1:0] dd_in,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    input  logic              snk_ready,
    output logic              snk_valid,
    output logic [DATA_W-1:0] snk_data
);
    // Timer width covers pulse + recovery + setup without saturating early.
    localparam int TW  = CFG_W + 2;
    localparam int PAD = TW - CFG_W;

    mdma_state_e state_q, state_d;

    // Transfer settings captured at arm time.
    logic              dir_q;
    logic [TW-1:0]     pw_eff, set_eff, cyc_eff;
    logic [DATA_W-1:0] wdata_q;
    logic              dev_stop_q;

    logic [TW-1:0]     ph_cnt, cy_cnt;
    logic [CNT_W-1:0]  words_left;
    logic              words_zero;

    logic start_go, stream_ok, strobe_last, setup_ok, cyc_ok;
    logic ph_clr, cy_clr, cy_preset, enter_setup;

    assign start_go    = (state_q == ST_IDLE) && xfer_start;
    assign stream_ok   = dir_q ? src_valid : snk_ready;
    assign strobe_last = (state_q == ST_STROBE) && (ph_cnt >= pw_eff - 1'b1);
    assign setup_ok    = ph_cnt >= set_eff - 1'b1;
    assign cyc_ok      = cy_cnt >= cyc_eff - 1'b1;
    assign ph_clr      = (state_d != state_q);
    assign cy_clr      = (state_q == ST_SETUP) && (state_d == ST_STROBE);
    assign cy_preset   = (state_q == ST_WAIT_RQ) && (state_d == ST_SETUP);
    assign enter_setup = (state_d == ST_SETUP) && (state_q != ST_SETUP);

    // Phase timer: clocks spent in the current state.
    mdma_tick_cnt #(.W(TW)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ph_clr),
        .preset (1'b0),
        .cnt    (ph_cnt)
    );

    // Cycle timer: clocks since the last strobe assertion; full at burst start.
    mdma_tick_cnt #(.W(TW)) u_cycle (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cy_clr),
        .preset (cy_preset),
        .cnt    (cy_cnt)
    );

    mdma_word_ctr #(.W(CNT_W)) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_go),
        .load_val (xfer_words),
        .dec      (strobe_last),
        .left     (words_left),
        .is_zero  (words_zero)
    );

    // Settings capture, write data latch, device-stop latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q      <= 1'b0;
            pw_eff     <= TW'(1);
            set_eff    <= TW'(1);
            cyc_eff    <= TW'(1);
            wdata_q    <= '0;
            dev_stop_q <= 1'b0;
        end else begin
            if (start_go) begin
                dir_q   <= cfg_write;
                pw_eff  <= (cfg_pulse == '0) ? TW'(1) : {{PAD{1'b0}}, cfg_pulse};
                set_eff <= (cfg_setup == '0) ? TW'(1) : {{PAD{1'b0}}, cfg_setup};
                cyc_eff <= (cfg_cycle == '0) ? TW'(1) : {{PAD{1'b0}}, cfg_cycle};
            end
            if (enter_setup) begin
                wdata_q <= src_data;
            end
            if (state_q == ST_SETUP) begin
                dev_stop_q <= 1'b0;
            end else if ((state_q == ST_STROBE) && !dmarq) begin
                dev_stop_q <= 1'b1;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (xfer_start) begin
                    state_d = (xfer_words == '0) ? ST_DONE : ST_WAIT_RQ;
                end
            end
            ST_WAIT_RQ: begin
                if (dmarq && stream_ok) begin
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (setup_ok && cyc_ok) begin
                    state_d = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (strobe_last) begin
                    state_d = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (words_zero) begin
                    state_d = ST_DONE;
                end else if (dev_stop_q || !stream_ok) begin
                    state_d = ST_WAIT_RQ;
                end else begin
                    state_d = ST_SETUP;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output decode.
    always_comb begin
        dmack_n   = 1'b1;
        dior_n    = 1'b1;
        diow_n    = 1'b1;
        dd_oe     = 1'b0;
        xfer_busy = 1'b1;
        xfer_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                xfer_busy = 1'b0;
            end
            ST_WAIT_RQ: begin
            end
            ST_SETUP, ST_RECOVER: begin
                dmack_n = 1'b0;
                dd_oe   = dir_q;
            end
            ST_STROBE: begin
                dmack_n = 1'b0;
                dd_oe   = dir_q;
                dior_n  = dir_q;
                diow_n  = !dir_q;
            end
            ST_DONE: begin
                xfer_done = 1'b1;
            end
            default: begin
                xfer_busy = 1'b0;
            end
        endcase
    end

    assign cs0_n     = 1'b1;
    assign cs1_n     = 1'b1;
    assign dd_out    = wdata_q;
    assign src_ready = strobe_last && dir_q;
    assign snk_valid = strobe_last && !dir_q;
    assign snk_data  = dd_in;

endmodule

// File: rtl/mdma_host_seq_chk.sv
module mdma_host_seq_chk #(
    parameter int TW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dmarq,
    input logic          dmack_n,
    input logic          dior_n,
    input logic          diow_n,
    input logic          dd_oe,
    input logic          xfer_done,
    input logic [TW-1:0] pw_eff,
    input logic [TW-1:0] cyc_eff
);
    logic          stb_n;
    logic          stb_prev_q, armed_q, drop_q;
    logic [TW:0]   wlen_q, gap_q;

    assign stb_n = dior_n && diow_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_prev_q <= 1'b1;
            armed_q    <= 1'b0;
            drop_q     <= 1'b0;
            wlen_q     <= '0;
            gap_q      <= '0;
        end else begin
            stb_prev_q <= stb_n;
            wlen_q     <= !stb_n ? wlen_q + 1'b1 : '0;
            if (!stb_n && stb_prev_q) begin
                gap_q <= 1;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
            if (dmack_n) begin
                armed_q <= 1'b0;
            end else if (!stb_n && stb_prev_q) begin
                armed_q <= 1'b1;
            end
            if (!stb_n && !dmarq) begin
                drop_q <= 1'b1;
            end else if (dmack_n) begin
                drop_q <= 1'b0;
            end
        end
    end

    // R2: acknowledge only follows a request
    a_r2_ack_after_rq: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dmack_n) |-> $past(dmarq));

    // R3: strobes only under acknowledge, never both
    a_r3_strobe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_n |-> !dmack_n);
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));

    // R4: pulse width
    a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_n) |-> (wlen_q == {1'b0, pw_eff}));

    // R5: minimum cycle inside a burst
    a_r5_cycle_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stb_n) && armed_q) |-> (gap_q >= {1'b0, cyc_eff}));

    // R6: write strobe only with bus driven
    a_r6_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !diow_n |-> dd_oe);

    // R8: device drop ends the burst after the recovery clock
    a_r8_dev_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stb_n) && (drop_q || !$past(dmarq))) |=> dmack_n);

    // R10: completion with the bus released
    a_r10_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (dmack_n && stb_n && !dd_oe));
endmodule

bind mdma_host_seq mdma_host_seq_chk #(.TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dmarq     (dmarq),
    .dmack_n   (dmack_n),
    .dior_n    (dior_n),
    .diow_n    (diow_n),
    .dd_oe     (dd_oe),
    .xfer_done (xfer_done),
    .pw_eff    (pw_eff),
    .cyc_eff   (cyc_eff)
);

// File: tb/mdma_host_seq_tb.sv
module mdma_host_seq_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       dir;
        logic [7:0] words;
        logic [7:0] pw;
        logic [7:0] cyc;
        logic [7:0] setup;
        logic [7:0] avail;
        logic [7:0] stop;
        logic [3:0] bursts;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'd4, 8'd3, 8'd0,  8'd1, 8'd4, 8'd0, 4'd1},
        '{1'b0, 8'd4, 8'd2, 8'd10, 8'd1, 8'd4, 8'd0, 4'd1},
        '{1'b1, 8'd5, 8'd4, 8'd6,  8'd2, 8'd2, 8'd0, 4'd2},
        '{1'b0, 8'd5, 8'd1, 8'd3,  8'd0, 8'd3, 8'd0, 4'd2},
        '{1'b1, 8'd5, 8'd3, 8'd8,  8'd1, 8'd5, 8'd2, 4'd2},
        '{1'b0, 8'd6, 8'd2, 8'd4,  8'd3, 8'd6, 8'd4, 4'd2},
        '{1'b1, 8'd3, 8'd2, 8'd5,  8'd1, 8'd3, 8'd3, 4'd1},
        '{1'b0, 8'd4, 8'd3, 8'd5,  8'd1, 8'd2, 8'd2, 4'd2},
        '{1'b1, 8'd0, 8'd2, 8'd2,  8'd1, 8'd0, 8'd0, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_write = 1'b0;
    logic [7:0]  cfg_pulse = '0, cfg_cycle = '0, cfg_setup = '0;
    logic        xfer_start = 1'b0;
    logic [15:0] xfer_words = '0;
    logic        xfer_busy, xfer_done;
    logic        dmarq = 1'b0;
    logic        dmack_n, cs0_n, cs1_n, dior_n, diow_n;
    logic [15:0] dd_in = '0;
    logic [15:0] dd_out;
    logic        dd_oe;
    logic        src_valid;
    logic [15:0] src_data;
    logic        src_ready;
    logic        snk_ready;
    logic        snk_valid;
    logic [15:0] snk_data;

    int n_chk = 0;
    int n_fail = 0;

    // Bench-side stream and device model state
    int src_rd, src_lim, snk_cnt, cap;
    int pulses, bursts, burst_pulses, per_cnt, wcnt, run, hi_cnt, gap;
    int v_pw, v_set, v_per, v_stop, v_words;
    logic v_dir, prev_stb, prev_dmack_n, stopping, done_seen;
    logic [15:0] last_dd;

    assign src_valid = (src_rd < src_lim);
    assign src_data  = 16'hA000 + 16'(src_rd);
    assign snk_ready = (snk_cnt < cap);

    always #(CLK_PERIOD/2) clk = ~clk;

    mdma_host_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_write(cfg_write), .cfg_pulse(cfg_pulse),
        .cfg_cycle(cfg_cycle), .cfg_setup(cfg_setup), .xfer_start(xfer_start),
        .xfer_words(xfer_words), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
        .dmarq(dmarq), .dmack_n(dmack_n), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .dior_n(dior_n), .diow_n(diow_n), .dd_in(dd_in), .dd_out(dd_out),
        .dd_oe(dd_oe), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .snk_ready(snk_ready), .snk_valid(snk_valid),
        .snk_data(snk_data)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // One clock of the device/stream model, sampled at the falling edge.
    task automatic step();
        logic stb;
        @(negedge clk);
        stb = !dior_n || !diow_n;
        if (!dmack_n && prev_dmack_n) begin
            bursts++;
            burst_pulses = 0;
        end
        if (stb && dmack_n) chk(1'b0, "R3 strobe without ack", 1, 0);
        if (stb && !prev_stb) begin
            pulses++;
            chk(v_dir ? (!diow_n && dior_n) : (!dior_n && diow_n), "R3 strobe line",
                {dior_n, diow_n}, v_dir ? 2 : 1);
            if (burst_pulses > 0) chk(per_cnt + 1 == v_per, "R5 period", per_cnt + 1, v_per);
            if (v_dir) begin
                chk(dd_oe && run >= v_set, "R6 setup", run, v_set);
                chk(dd_out == 16'hA000 + 16'(pulses - 1), "R6 data at strobe",
                    dd_out, 16'hA000 + pulses - 1);
            end
            burst_pulses++;
            per_cnt = 0;
            dd_in = 16'h5000 + 16'(pulses - 1);
            if (pulses == v_stop) begin
                dmarq = 1'b0;
                stopping = 1'b1;
                gap = 0;
            end
        end else begin
            per_cnt++;
        end
        if (stb) wcnt++;
        if (!stb && prev_stb) begin
            chk(wcnt == v_pw, "R4 width", wcnt, v_pw);
            wcnt = 0;
            if (v_dir) chk(dd_oe && dd_out == 16'hA000 + 16'(pulses - 1), "R6 hold",
                           dd_out, 16'hA000 + pulses - 1);
        end
        if (dd_oe) run = (dd_out == last_dd) ? run + 1 : 1;
        else run = 0;
        last_dd = dd_out;
        if (snk_valid) begin
            chk(!v_dir && snk_data == 16'h5000 + 16'(snk_cnt) && stb, "R7 read word",
                snk_data, 16'h5000 + snk_cnt);
            snk_cnt++;
        end
        if (src_ready) src_rd++;
        if (xfer_done) begin
            done_seen = 1'b1;
            chk(dmack_n, "R10 done with ack released", dmack_n, 1);
        end
        if (dmack_n && xfer_busy && pulses > 0) hi_cnt++;
        else hi_cnt = 0;
        if (hi_cnt >= 3) begin
            src_lim = v_words;
            cap = v_words;
        end
        if (stopping && dmack_n) begin
            gap++;
            if (gap >= 3) begin
                dmarq = 1'b1;
                stopping = 1'b0;
            end
        end
        prev_stb = stb;
        prev_dmack_n = dmack_n;
    endtask

    task automatic run_vec(input vec_t v, input int rq_delay, input logic restart);
        string tag;
        int moved;
        v_dir   = v.dir;
        v_words = int'(v.words);
        v_pw    = (v.pw == 0) ? 1 : int'(v.pw);
        v_set   = (v.setup == 0) ? 1 : int'(v.setup);
        v_per   = v_pw + 1 + v_set;
        if (int'(v.cyc) > v_per) v_per = int'(v.cyc);
        v_stop  = int'(v.stop);
        cfg_write = v.dir; cfg_pulse = v.pw; cfg_cycle = v.cyc; cfg_setup = v.setup;
        xfer_words = {8'd0, v.words};
        src_rd = 0; src_lim = int'(v.avail); snk_cnt = 0; cap = int'(v.avail);
        pulses = 0; bursts = 0; burst_pulses = 0; per_cnt = 0; wcnt = 0; run = 0;
        hi_cnt = 0; gap = 0; stopping = 1'b0; done_seen = 1'b0;
        prev_stb = 1'b0; prev_dmack_n = 1'b1; last_dd = '0;
        dmarq = 1'b0;
        xfer_start = 1'b1;
        step();
        xfer_start = 1'b0;
        for (int i = 0; i < rq_delay; i++) begin
            if (restart && i == 2) begin
                xfer_start = 1'b1;
                xfer_words = {8'd0, v.words} + 16'd3;
            end else begin
                xfer_start = 1'b0;
            end
            step();
            chk(dmack_n, "R2 no ack without request", dmack_n, 1);
        end
        xfer_start = 1'b0;
        dmarq = 1'b1;
        for (int i = 0; i < 3000 && !done_seen; i++) step();
        step();
        step();
        dmarq = 1'b0;
        if (v_stop != 0) tag = "R8 bursts";
        else if (v.avail < v.words) tag = "R9 bursts";
        else tag = "R2 bursts";
        chk(done_seen, "R10 done seen", done_seen, 1);
        chk(pulses == v_words, "R10 word count", pulses, v_words);
        chk(bursts == int'(v.bursts), tag, bursts, int'(v.bursts));
        moved = v.dir ? src_rd : snk_cnt;
        chk(moved == v_words, v.dir ? "R6 words popped" : "R7 words stored", moved, v_words);
        chk(!xfer_busy && dmack_n && dd_oe == 1'b0, "R1 idle after transfer",
            {xfer_busy, dmack_n, dd_oe}, 3'b010);
        if (restart) chk(pulses == v_words, "R11 start ignored while busy", pulses, v_words);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dmack_n && dior_n && diow_n && cs0_n && cs1_n && !dd_oe && !xfer_busy,
            "R1 reset outputs", {dmack_n, dior_n, diow_n, cs0_n, cs1_n, dd_oe, xfer_busy},
            7'b1111100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dmack_n && !xfer_busy && !xfer_done, "R1 idle after reset",
            {dmack_n, xfer_busy, xfer_done}, 3'b100);

        for (int k = 0; k < NV; k++) run_vec(VEC[k], 0, 1'b0);

        // Directed: request held off, and a second start while busy (R2, R11)
        run_vec(VEC[0], 8, 1'b1);
        run_vec(VEC[1], 6, 1'b1);

        // Directed: chip selects stay negated through a whole run (R1)
        chk(cs0_n && cs1_n, "R1 chip selects", {cs0_n, cs1_n}, 3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule